// File: doc/BRIEF.md
# Per-Pin Interrupt Trigger Detector

This block turns the sampled levels of one bank of general-purpose pins into interrupt requests. The bank holds `PORTS` ports of `PINS` pins each, 32 pins by default. For every pin, a three-bit field picks one trigger mode: rising edge, falling edge, both edges, high level or low level. The block keeps one status bit per pin and gates it with a per-pin enable. It ORs every gated bit in the bank into a single interrupt line.

The pin levels must already be synchronised to `clk`. The register decoding sits outside this block. The trigger words, the enable mask and the write-one-to-clear pulses arrive as plain inputs. Reset is synchronous and active low. While reset is held, the edge-history flops load the current pin levels, so a pin that is already high when reset releases does not count as an edge.

Top module: `gpio_irq_detect`

## Requirements
- R1: Port p owns `trig_cfg[24p +: 24]`. Pin k = 8p+n is the status, enable, clear and level index of pin n of port p. In that word:
  - bit n is the polarity (1 = high/rising).
  - bit 8+n is the edge select (1 = edge mode).
  - bit 16+n is the both-edges flag, which is ignored when the edge select is 0.
- R2: Rising-edge mode (edge=1, polarity=1, both=0) sets status bit k at the clock edge where `pin_lvl[k]` is 1 and was 0 on the previous edge. The status is visible right after that edge.
- R3: Falling-edge mode (edge=1, polarity=0, both=0) sets status bit k on a 1-to-0 change. A 0-to-1 change in this mode does not set it.
- R4: Both-edges mode (edge=1, both=1) sets status bit k on either change. A steady level does not set it.
- R5: Level modes (edge=0) make status bit k equal the active level seen at the previous clock edge. Polarity 1 means high is active and polarity 0 means low is active.
- R6: In edge mode, `irq_clr[k]`=1 for one cycle clears status bit k at that clock edge. A 0 in `irq_clr` leaves the bit unchanged.
- R7: If an edge and a clear reach the same pin on the same clock edge, the status bit ends up set.
- R8: In level mode a clear has no effect. The status stays 1 while the level stays active.
- R9: `irq_pend` = `irq_stat` AND `irq_en`. `irq_out` is high exactly when some pin in any port is pending.
- R10: After reset, `irq_stat` is all zero. No edge is detected on the first cycle after reset, even if pins were held high through reset.
- R11: After an edge-mode status bit is cleared, a later edge on that pin sets it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_lvl | input | PORTS*PINS | Synchronised pin levels |
| trig_cfg | input | PORTS*3*PINS | Trigger-mode words, one per port |
| irq_en | input | PORTS*PINS | Per-pin interrupt enable |
| irq_clr | input | PORTS*PINS | Write-one-to-clear pulses for status |
| irq_stat | output | PORTS*PINS | Per-pin status bits |
| irq_pend | output | PORTS*PINS | Status gated by enable |
| irq_out | output | 1 | Combined bank interrupt |

## Verification
The checker watches several properties on every cycle:
- An edge-mode status bit never drops without a clear.
- A level-mode status bit always matches the previous cycle's active level, whatever clears arrive.
- An edge-mode status bit cannot rise while the pin level is steady.
- The combined output never rises without an enabled status bit.
- Status is zero right after reset.

The exact decoding of each of the five mode encodings needs the bench's scenarios, as does a clear arriving together with an edge. So does recapture after a clear, and the OR across ports.

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int PORTS = 4,
  parameter int PINS  = 8,
  localparam int NPIN = PORTS * PINS,
  localparam int CFGW = 3 * PINS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NPIN-1:0]       pin_lvl,
  input  logic [PORTS*CFGW-1:0] trig_cfg,
  input  logic [NPIN-1:0]       irq_en,
  input  logic [NPIN-1:0]       irq_clr,
  output logic [NPIN-1:0]       irq_stat,
  output logic [NPIN-1:0]       irq_pend,
  output logic                  irq_out
);

  logic [NPIN-1:0] pol, edg, both;
  logic [NPIN-1:0] prev_lvl, rise, fall, edge_hit, lvl_act;

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    for (genvar n = 0; n < PINS; n++) begin : g_pin
      assign pol[p*PINS+n]  = trig_cfg[p*CFGW + n];
      assign edg[p*PINS+n]  = trig_cfg[p*CFGW + PINS + n];
      assign both[p*PINS+n] = trig_cfg[p*CFGW + 2*PINS + n];
    end
  end

  assign rise     = pin_lvl & ~prev_lvl;
  assign fall     = ~pin_lvl & prev_lvl;
  assign edge_hit = (both & (rise | fall)) | (~both & pol & rise) | (~both & ~pol & fall);
  assign lvl_act  = ~(pin_lvl ^ pol);

  always_ff @(posedge clk) begin
    prev_lvl <= pin_lvl;
    if (!rst_n) irq_stat <= '0;
    else        irq_stat <= (edg & (edge_hit | (irq_stat & ~irq_clr))) | (~edg & lvl_act);
  end

  assign irq_pend = irq_stat & irq_en;
  assign irq_out  = |irq_pend;

endmodule

// File: rtl/gpio_irq_detect_chk.sv
module gpio_irq_detect_chk #(
  parameter int PORTS = 4,
  parameter int PINS  = 8,
  localparam int NPIN = PORTS * PINS,
  localparam int CFGW = 3 * PINS
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NPIN-1:0]       pin_lvl,
  input logic [PORTS*CFGW-1:0] trig_cfg,
  input logic [NPIN-1:0]       irq_en,
  input logic [NPIN-1:0]       irq_clr,
  input logic [NPIN-1:0]       irq_stat,
  input logic                  irq_out
);

  logic [NPIN-1:0] c_edg, c_pol;

  always_comb begin
    for (int k = 0; k < NPIN; k++) begin
      c_pol[k] = trig_cfg[(k / PINS) * CFGW + (k % PINS)];
      c_edg[k] = trig_cfg[(k / PINS) * CFGW + PINS + (k % PINS)];
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (irq_stat == '0) && !irq_out); // R10

  AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (($past(irq_stat) & ~$past(irq_clr) & $past(c_edg) & ~irq_stat) == '0)); // R6

  AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (((irq_stat ^ ~($past(pin_lvl) ^ $past(c_pol))) & ~$past(c_edg)) == '0)); // R8

  AST_EDGE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((~$past(irq_stat) & $past(c_edg) & ~($past(pin_lvl) ^ $past(pin_lvl, 2)) & irq_stat) == '0)); // R4

  AST_OUT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> ((irq_stat & irq_en) != '0)); // R9

endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(.PORTS(PORTS), .PINS(PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .trig_cfg(trig_cfg),
  .irq_en(irq_en), .irq_clr(irq_clr), .irq_stat(irq_stat), .irq_out(irq_out)
);

// File: tb/gpio_irq_detect_tb.sv
module gpio_irq_detect_tb;
  localparam int PORTS = 4;
  localparam int PINS  = 8;
  localparam int NPIN  = PORTS * PINS;
  localparam int CFGW  = 3 * PINS;
  localparam int PIN_A = 21;

  // entry: {both, edge, pol, level_before, level_after, expected_status}
  localparam logic [5:0] VEC [14] = '{
    6'b011_01_1, 6'b011_10_0, 6'b011_11_0,
    6'b010_10_1, 6'b010_01_0,
    6'b110_01_1, 6'b110_10_1, 6'b110_00_0,
    6'b001_01_1, 6'b001_10_0,
    6'b000_10_1, 6'b000_01_0,
    6'b101_01_1, 6'b101_10_0
  };

  logic                  clk = 0;
  logic                  rst_n;
  logic [NPIN-1:0]       pin_lvl, irq_en, irq_clr;
  logic [PORTS*CFGW-1:0] trig_cfg;
  logic [NPIN-1:0]       irq_stat, irq_pend;
  logic                  irq_out;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_irq_detect #(.PORTS(PORTS), .PINS(PINS)) u_dut (
    .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .trig_cfg(trig_cfg),
    .irq_en(irq_en), .irq_clr(irq_clr), .irq_stat(irq_stat),
    .irq_pend(irq_pend), .irq_out(irq_out)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic set_cfg(int k, logic [2:0] c);
    trig_cfg[(k/PINS)*CFGW + (k%PINS)]          = c[0];
    trig_cfg[(k/PINS)*CFGW + PINS + (k%PINS)]   = c[1];
    trig_cfg[(k/PINS)*CFGW + 2*PINS + (k%PINS)] = c[2];
  endtask

  function automatic string tag_of(logic [2:0] c);
    if (c[1] && c[2]) return "R4";
    if (c[1] && c[0]) return "R2";
    if (c[1])         return "R3";
    if (c[2])         return "R1";
    return "R5";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; pin_lvl = '1; irq_en = '1; irq_clr = '0;
    for (int p = 0; p < PORTS; p++) trig_cfg[p*CFGW +: CFGW] = 24'h00FFFF;
    repeat (3) tick();
    rst_n = 1;
    tick();
    chk("R10 stat after reset", irq_stat, '0);
    chk("R10 irq after reset", irq_out, 0);
    tick();
    chk("R10 steady high pins", irq_stat, '0);

    trig_cfg = '0; pin_lvl = '0; irq_en = '0;
    foreach (VEC[i]) begin
      set_cfg(PIN_A, VEC[i][5:3]);
      pin_lvl[PIN_A] = VEC[i][2];
      tick(); tick();
      irq_clr = '1; tick(); irq_clr = '0;
      pin_lvl[PIN_A] = VEC[i][1];
      tick();
      chk($sformatf("%s vec%0d", tag_of(VEC[i][5:3]), i), irq_stat[PIN_A], VEC[i][0]);
    end

    set_cfg(PIN_A, 3'b011);
    pin_lvl[PIN_A] = 0; tick(); tick();
    irq_clr = '1; tick(); irq_clr = '0;
    pin_lvl[PIN_A] = 1; tick();
    chk("R2 rising", irq_stat[PIN_A], 1);
    irq_clr = ~(NPIN'(1) << PIN_A); tick(); irq_clr = '0;
    chk("R6 zero clear keeps", irq_stat[PIN_A], 1);
    tick();
    chk("R6 sticky", irq_stat[PIN_A], 1);

    chk("R9 pend masked", irq_pend[PIN_A], 0);
    chk("R9 out masked", irq_out, 0);
    irq_en = NPIN'(1) << PIN_A; #1;
    chk("R9 pend", irq_pend, NPIN'(1) << PIN_A);
    chk("R9 out", irq_out, 1);
    irq_en = NPIN'(1) << 30; #1;
    chk("R9 port3 level-low pin", irq_out, 1);
    irq_en = '0;

    irq_clr = NPIN'(1) << PIN_A; tick(); irq_clr = '0;
    chk("R6 cleared", irq_stat[PIN_A], 0);
    pin_lvl[PIN_A] = 0; tick();
    pin_lvl[PIN_A] = 1; tick();
    chk("R11 recapture", irq_stat[PIN_A], 1);
    pin_lvl[PIN_A] = 0; irq_clr = NPIN'(1) << PIN_A; tick();
    chk("R6 clear", irq_stat[PIN_A], 0);
    pin_lvl[PIN_A] = 1; tick(); irq_clr = '0;
    chk("R7 edge beats clear", irq_stat[PIN_A], 1);

    set_cfg(PIN_A, 3'b001);
    pin_lvl[PIN_A] = 1; tick();
    chk("R5 level high", irq_stat[PIN_A], 1);
    irq_clr = NPIN'(1) << PIN_A; tick(); irq_clr = '0;
    chk("R8 clear ignored", irq_stat[PIN_A], 1);
    tick();
    chk("R8 still set", irq_stat[PIN_A], 1);
    pin_lvl[PIN_A] = 0; tick();
    chk("R5 level drop", irq_stat[PIN_A], 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule